// File: doc/BRIEF.md
# Shifting Return-Address Stack

This block is a small last-in, first-out store built as a chain of registers. Each push shifts every level one place down and puts the new word on top. Each pop shifts every level one place up. The top level is always visible on the read port without a clock edge, so a pop hands over the word that was on top just before the edge.

The stack never refuses an operation and never reports its fill level. A push into a full stack pushes the oldest word off the bottom and loses it. A pop copies the bottom level into itself rather than clearing it. Once the stack has been drained, further pops keep returning the last valid word.

Because of this, a caller can save the whole stack without knowing how deep it is in use. It pops as many times as there are levels, and later pushes the saved words back in reverse order to restore the exact contents.

Top module: `shift_stack`

## Requirements
- R1: The stack has DEPTH levels (default 8), each WIDTH bits wide (default 22). The top level appears combinationally on `topData`, and every bit of a full-width value such as 22'h3FFFFF is kept.
- R2: A push alone (`pushEn`=1, `popEn`=0) makes `topData` equal to the `pushData` of that cycle after the clock edge, and moves each older level one place toward the bottom.
- R3: A push while all levels hold data discards the bottom word. After ten pushes of v1..v10 into an empty stack, the next eight pops return v10 down to v3, so v1 and v2 are gone.
- R4: A pop alone (`pushEn`=0, `popEn`=1) returns the value shown on `topData` before the edge, and afterwards `topData` shows the level that was second.
- R5: A pop leaves the bottom level unchanged. Once the stack has been emptied, every further pop returns the last valid word again.
- R6: When push and pop are both asserted in one cycle, only the top level changes, to `pushData`. All deeper levels keep their values.
- R7: With neither strobe asserted, no level changes.
- R8: A synchronous active-high `rst` clears all levels to zero. Pops made straight after a reset all return zero.
- R9: Popping DEPTH times and then pushing the popped words back in reverse order restores the original contents level for level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears every level |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| pushData | input | WIDTH | Word written on a push |
| topData | output | WIDTH | Current top level, shown combinationally |

## Verification
The assertions assume that `pushEn`, `popEn` and `pushData` carry known values on every clock edge outside reset. They also assume that `rst` is held for at least one rising edge so that its clearing effect can be seen. The bench changes its inputs a short time after each rising edge and returns both strobes to zero after every operation, so no strobe is ever unknown or changing at an edge. Reset is applied at start-up and again in the middle of the run, with words still stacked, to show that clearing does not depend on the fill level.

// File: rtl/shift_stack_pkg.sv
package shift_stack_pkg;
  // Strobes from the control decode to the register chain
  typedef struct packed {
    logic loadTop;    // write pushData into level 0
    logic shiftDown;  // level i takes level i-1 (toward bottom)
    logic shiftUp;    // level i takes level i+1 (toward top)
  } stackCmd_t;
endpackage

// File: rtl/shift_stack_ctrl.sv
module shift_stack_ctrl
  import shift_stack_pkg::*;
(
  input  logic      pushEn,
  input  logic      popEn,
  output stackCmd_t cmd
);
  always_comb begin
    cmd = '0;
    unique case ({pushEn, popEn})
      2'b10: begin
        cmd.loadTop   = 1'b1;
        cmd.shiftDown = 1'b1;
      end
      2'b01: cmd.shiftUp = 1'b1;
      2'b11: cmd.loadTop = 1'b1;   // replace top only
      default: ;
    endcase
  end
endmodule

// File: rtl/shift_stack_data.sv
module shift_stack_data
  import shift_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  stackCmd_t        cmd,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] topData
);
  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] levels  [DEPTH];
  logic [WIDTH-1:0] nextLvl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    if (i == 0) begin : g_top
      always_comb begin
        if (cmd.loadTop)      nextLvl[i] = wrData;
        else if (cmd.shiftUp) nextLvl[i] = levels[i+1];
        else                  nextLvl[i] = levels[i];
      end
    end else if (i == LAST) begin : g_bottom
      // bottom keeps its value on a pop
      always_comb begin
        if (cmd.shiftDown) nextLvl[i] = levels[i-1];
        else               nextLvl[i] = levels[i];
      end
    end else begin : g_mid
      always_comb begin
        if (cmd.shiftDown)    nextLvl[i] = levels[i-1];
        else if (cmd.shiftUp) nextLvl[i] = levels[i+1];
        else                  nextLvl[i] = levels[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) levels[i] <= '0;
      else     levels[i] <= nextLvl[i];
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk) rst |=> levels[i] == '0);
  end

  assign topData = levels[0];

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.loadTop && cmd.shiftDown) |=> topData == $past(wrData));
  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.shiftDown |=> levels[1] == $past(levels[0]));
  // R4
  pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.shiftUp |=> topData == $past(levels[1]));
  // R5
  pop_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.shiftUp |=> $stable(levels[LAST]));
  // R6
  both_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.loadTop && !cmd.shiftDown) |=> $stable(levels[1]) && $stable(levels[LAST]));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == '0) |=> $stable(topData) && $stable(levels[LAST]));
endmodule

// File: rtl/shift_stack.sv
module shift_stack
  import shift_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData
);
  stackCmd_t cmd;

  shift_stack_ctrl i_ctrl (
    .pushEn (pushEn),
    .popEn  (popEn),
    .cmd    (cmd)
  );

  shift_stack_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_data (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .wrData  (pushData),
    .topData (topData)
  );

  // R6
  both_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pushEn && popEn) |=> topData == $past(pushData));
endmodule

// File: tb/test_shift_stack.sv
module test_shift_stack;
  localparam int DEPTH = 8;
  localparam int WIDTH = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pushEn = 1'b0;
  logic popEn = 1'b0;
  logic [WIDTH-1:0] pushData = '0;
  logic [WIDTH-1:0] topData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  shift_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_shift_stack (
    .clk(clk), .rst(rst), .pushEn(pushEn), .popEn(popEn),
    .pushData(pushData), .topData(topData)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one operation; inputs change 2 ns after an edge
  task automatic op(input logic p, input logic q, input logic [WIDTH-1:0] d);
    pushEn = p; popEn = q; pushData = d;
    @(posedge clk); #2;
    pushEn = 0; popEn = 0;
  endtask

  task automatic doReset();
    rst = 1; @(posedge clk); #2; rst = 0;
  endtask

  task automatic pop(output logic [WIDTH-1:0] v);
    v = topData;
    op(0, 1, '0);
  endtask

  task automatic testReset();
    logic [WIDTH-1:0] v;
    doReset();
    check("R8 top after reset", topData, '0);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      check("R8 pop after reset", v, '0);
    end
  endtask

  task automatic testPushOne();
    op(1, 0, 22'h3FFFFF);
    check("R1 full width top", topData, 22'h3FFFFF);
    op(1, 0, 22'h000123);
    check("R2 push top", topData, 22'h000123);
  endtask

  task automatic testOverflow();
    logic [WIDTH-1:0] v;
    doReset();
    for (int i = 1; i <= 10; i++) begin
      op(1, 0, WIDTH'(22'h100 + i));
      check("R2 top after push", topData, WIDTH'(22'h100 + i));
    end
    for (int k = 0; k < DEPTH; k++) begin
      pop(v);
      check("R3 pop order after overflow", v, WIDTH'(22'h100 + 10 - k));
    end
    for (int k = 0; k < 2; k++) begin
      pop(v);
      check("R5 underflow repeats bottom", v, 22'h103);
    end
    check("R5 top after drain", topData, 22'h103);
  endtask

  task automatic testBoth();
    logic [WIDTH-1:0] v;
    doReset();
    op(1, 0, 22'h0A);
    op(1, 0, 22'h0B);
    op(1, 0, 22'h0C);
    op(1, 1, 22'h0D);
    check("R6 top replaced", topData, 22'h0D);
    pop(v);
    check("R4 pop returns prior top", v, 22'h0D);
    check("R6 second level kept", topData, 22'h0B);
    pop(v);
    check("R6 third level kept", topData, 22'h0A);
  endtask

  task automatic testIdle();
    op(1, 0, 22'h2AAAAA);
    repeat (3) op(0, 0, 22'h155555);
    check("R7 idle hold", topData, 22'h2AAAAA);
  endtask

  task automatic testSaveRestore();
    logic [WIDTH-1:0] saved [DEPTH];
    logic [WIDTH-1:0] v;
    doReset();
    for (int i = 0; i < DEPTH; i++) op(1, 0, WIDTH'(22'h3F0000 + i * 7));
    for (int i = 0; i < DEPTH; i++) pop(saved[i]);
    for (int i = DEPTH - 1; i >= 0; i--) op(1, 0, saved[i]);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      check("R9 restored level", v, WIDTH'(22'h3F0000 + (DEPTH - 1 - i) * 7));
    end
  endtask

  task automatic testMidReset();
    logic [WIDTH-1:0] v;
    op(1, 0, 22'h777);
    op(1, 0, 22'h888);
    doReset();
    check("R8 mid reset top", topData, '0);
    pop(v);
    pop(v);
    check("R8 mid reset deeper", v, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    @(posedge clk); #2;
    testReset();
    testPushOne();
    testOverflow();
    testBoth();
    testIdle();
    testSaveRestore();
    testMidReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule